// File: doc/BRIEF.md
# Five-Stage Load/Store Integer Pipeline

This block is a 32-bit in-order pipeline with five stages: fetch, decode, execute, memory and write-back. It runs a small register-register and load/store subset of a classic three-operand instruction set: add, subtract, bitwise and, bitwise or, word load and word store. The program counter steps by four every cycle. It addresses an internal instruction store, and the fetched word lands in the fetch/decode register.

Decode reads two operands from a 32-entry register file. The register file is read combinationally and written on the falling clock edge. Decode also builds the control flags, sign-extends the 16-bit immediate and picks the destination register number. All operand bypassing happens in decode. An external hazard unit drives a 2-bit select for each operand and a stall request. The core exports the register numbers and flags that the hazard unit needs to make those choices.

A testbench preloads both memories through simple write ports while reset is held. Results are observed at the registered write-back outputs.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `pc_o` = 0, and `wb_en_o`, `ex_wreg_o` and `mem_wreg_o` are all cleared.
- R2: With `stall_i` low, each rising edge adds 4 to `pc_o` and loads the instruction word at `pc_o[IMEM_AW+1:2]` into the decode register. `dec_rs_o` and `dec_rt_o` show bits 25:21 and 20:16 of the word held in decode.
- R3: Instruction encodings:
  - Opcode 0x00 with funct 0x20, 0x22, 0x24 or 0x25 selects add, sub, and or or.
  - Opcode 0x23 is a word load.
  - Opcode 0x2B is a word store.
  - Any other word, including all-zero, writes neither a register nor memory.
- R4: The ALU computes a+b, a-b, a&b or a|b in 32-bit wrap-around arithmetic.
- R5: For loads and stores, the second ALU operand is bits 15:0 sign-extended, and the ALU sum is the byte address. Data memory is indexed by address bits `DMEM_AW+1:2`.
- R6: The destination register is bits 15:11 for register-register operations and bits 20:16 for loads.
- R7: A store writes its second source register value to data memory at the rising edge that ends its memory stage. No other instruction writes data memory.
- R8: Write-back data is the data-memory word for loads and the ALU result otherwise. `wb_en_o`, `wb_rn_o` and `wb_data_o` appear one edge after the instruction's memory stage.
- R9: A register written in write-back is seen by the instruction in decode during that same cycle, with a select of 00.
- R10: Register 0 always reads as zero, and writes to it are dropped.
- R11: Operand select codes, driven per operand while an instruction sits in decode:
  - 00 takes the register file.
  - 01 takes the execute-stage ALU result.
  - 10 takes the memory-stage ALU result.
  - 11 takes the memory-stage load data.
- R12: A high `stall_i` at a rising edge holds `pc_o` and the decode register, and puts a bubble with all write flags clear into execute.
- R13: `ex_rn_o`, `ex_wreg_o` and `ex_m2reg_o` describe the execute-stage instruction. The `mem_*` outputs describe the same instruction one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Hold fetch and decode, bubble into execute |
| fwd_a_i | input | 2 | First operand select for the decode instruction |
| fwd_b_i | input | 2 | Second operand select for the decode instruction |
| imem_ld_en_i | input | 1 | Instruction store preload write enable |
| imem_ld_addr_i | input | IMEM_AW | Instruction store word index |
| imem_ld_data_i | input | 32 | Instruction word to preload |
| dmem_ld_en_i | input | 1 | Data store preload write enable |
| dmem_ld_addr_i | input | DMEM_AW | Data store word index |
| dmem_ld_data_i | input | 32 | Data word to preload |
| pc_o | output | 32 | Program counter |
| dec_rs_o | output | 5 | First source register number in decode |
| dec_rt_o | output | 5 | Second source register number in decode |
| ex_rn_o | output | 5 | Destination number in execute |
| ex_wreg_o | output | 1 | Execute instruction writes a register |
| ex_m2reg_o | output | 1 | Execute instruction is a load |
| mem_rn_o | output | 5 | Destination number in memory stage |
| mem_wreg_o | output | 1 | Memory-stage instruction writes a register |
| mem_m2reg_o | output | 1 | Memory-stage instruction is a load |
| wb_en_o | output | 1 | Write-back instruction writes a register |
| wb_rn_o | output | 5 | Write-back destination number |
| wb_data_o | output | 32 | Write-back data |

## Verification
Two things can fall in the same cycle: the falling-edge register write of the write-back instruction and the combinational operand read of the decode instruction. The program places a consumer exactly three slots after its producer and drives a select of 00, so only the same-cycle write can deliver the fresh value. The same placement is used with a write to register 0 followed by a read of register 0, which must still yield zero. Each case is judged by the consumer's own write-back value. Stall and load-data forwarding are also combined: a load-use pair is stalled one cycle, then resolved with select 11.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam int RN_W = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_RF   = 2'b00,
    SRC_EXE  = 2'b01,
    SRC_MALU = 2'b10,
    SRC_MDAT = 2'b11
  } opnd_src_e;

  typedef struct packed {
    logic    wreg;
    logic    m2reg;
    logic    wmem;
    logic    use_imm;
    logic    rd_dst;
    alu_op_e op;
  } ctrl_t;

endpackage

// File: rtl/p5_ctrl.sv
module p5_ctrl
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.rd_dst = 1'b1;
        unique case (funct)
          FN_ADD:  begin ctrl.wreg = 1'b1; ctrl.op = ALU_ADD; end
          FN_SUB:  begin ctrl.wreg = 1'b1; ctrl.op = ALU_SUB; end
          FN_AND:  begin ctrl.wreg = 1'b1; ctrl.op = ALU_AND; end
          FN_OR:   begin ctrl.wreg = 1'b1; ctrl.op = ALU_OR;  end
          default: ctrl = '0;
        endcase
      end
      OP_LOAD: begin
        ctrl.wreg    = 1'b1;
        ctrl.m2reg   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.op      = ALU_ADD;
      end
      OP_STORE: begin
        ctrl.wmem    = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.op      = ALU_ADD;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/p5_alu.sv
module p5_alu
  import pipe5_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/p5_regfile.sv
module p5_regfile #(
  parameter int W    = 32,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] regs [DEPTH];

  // written mid-cycle so the decode read in the same cycle sees it
  always_ff @(negedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];

endmodule

// File: rtl/p5_ram.sv
module p5_ram #(
  parameter int W  = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stall_i,
  input  logic [1:0]          fwd_a_i,
  input  logic [1:0]          fwd_b_i,
  input  logic                imem_ld_en_i,
  input  logic [IMEM_AW-1:0]  imem_ld_addr_i,
  input  logic [31:0]         imem_ld_data_i,
  input  logic                dmem_ld_en_i,
  input  logic [DMEM_AW-1:0]  dmem_ld_addr_i,
  input  logic [XLEN-1:0]     dmem_ld_data_i,
  output logic [XLEN-1:0]     pc_o,
  output logic [RN_W-1:0]     dec_rs_o,
  output logic [RN_W-1:0]     dec_rt_o,
  output logic [RN_W-1:0]     ex_rn_o,
  output logic                ex_wreg_o,
  output logic                ex_m2reg_o,
  output logic [RN_W-1:0]     mem_rn_o,
  output logic                mem_wreg_o,
  output logic                mem_m2reg_o,
  output logic                wb_en_o,
  output logic [RN_W-1:0]     wb_rn_o,
  output logic [XLEN-1:0]     wb_data_o
);

  localparam int IMM_W = 16;
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  // fetch
  logic [XLEN-1:0] pc_q;
  logic [31:0]     fetch_word;
  logic [31:0]     ifid_ir_q;

  p5_ram #(.W(32), .AW(IMEM_AW)) u_imem (
    .clk   (clk),
    .we    (imem_ld_en_i),
    .waddr (imem_ld_addr_i),
    .wdata (imem_ld_data_i),
    .raddr (pc_q[IMEM_AW+1:2]),
    .rdata (fetch_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      ifid_ir_q <= '0;
    end else if (!stall_i) begin
      pc_q      <= pc_q + PC_STEP;
      ifid_ir_q <= fetch_word;
    end
  end

  // decode
  logic [RN_W-1:0] d_rs, d_rt, d_rd, d_rn;
  logic [XLEN-1:0] d_imm, rf_qa, rf_qb, d_opa, d_opb;
  ctrl_t           d_ctrl;

  assign d_rs  = ifid_ir_q[25:21];
  assign d_rt  = ifid_ir_q[20:16];
  assign d_rd  = ifid_ir_q[15:11];
  assign d_imm = {{(XLEN-IMM_W){ifid_ir_q[IMM_W-1]}}, ifid_ir_q[IMM_W-1:0]};

  p5_ctrl u_ctrl (
    .opcode (ifid_ir_q[31:26]),
    .funct  (ifid_ir_q[5:0]),
    .ctrl   (d_ctrl)
  );

  assign d_rn = d_ctrl.rd_dst ? d_rd : d_rt;

  logic            wb_en_q;
  logic [RN_W-1:0] wb_rn_q;
  logic [XLEN-1:0] wb_data_q;

  p5_regfile #(.W(XLEN), .AW(RN_W)) u_rf (
    .clk (clk),
    .we  (wb_en_q),
    .wa  (wb_rn_q),
    .wd  (wb_data_q),
    .ra  (d_rs),
    .rb  (d_rt),
    .qa  (rf_qa),
    .qb  (rf_qb)
  );

  logic [XLEN-1:0] ex_alu_y;
  logic [XLEN-1:0] mem_alu_q;
  logic [XLEN-1:0] mem_rdata;

  function automatic logic [XLEN-1:0] pick_src(
    input logic [1:0]      sel,
    input logic [XLEN-1:0] rf_val,
    input logic [XLEN-1:0] exe_val,
    input logic [XLEN-1:0] malu_val,
    input logic [XLEN-1:0] mdat_val
  );
    unique case (opnd_src_e'(sel))
      SRC_EXE:  return exe_val;
      SRC_MALU: return malu_val;
      SRC_MDAT: return mdat_val;
      default:  return rf_val;
    endcase
  endfunction

  assign d_opa = pick_src(fwd_a_i, rf_qa, ex_alu_y, mem_alu_q, mem_rdata);
  assign d_opb = pick_src(fwd_b_i, rf_qb, ex_alu_y, mem_alu_q, mem_rdata);

  // decode / execute register
  ctrl_t           ex_ctrl_q;
  logic [XLEN-1:0] ex_a_q, ex_b_q, ex_imm_q;
  logic [RN_W-1:0] ex_rn_q;

  always_ff @(posedge clk) begin
    if (rst || stall_i) ex_ctrl_q <= '0;
    else                ex_ctrl_q <= d_ctrl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_a_q   <= '0;
      ex_b_q   <= '0;
      ex_imm_q <= '0;
      ex_rn_q  <= '0;
    end else begin
      ex_a_q   <= d_opa;
      ex_b_q   <= d_opb;
      ex_imm_q <= d_imm;
      ex_rn_q  <= d_rn;
    end
  end

  // execute
  logic [XLEN-1:0] ex_alu_b;
  assign ex_alu_b = ex_ctrl_q.use_imm ? ex_imm_q : ex_b_q;

  p5_alu #(.W(XLEN)) u_alu (
    .op (ex_ctrl_q.op),
    .a  (ex_a_q),
    .b  (ex_alu_b),
    .y  (ex_alu_y)
  );

  // execute / memory register
  logic            mem_wreg_q, mem_m2reg_q, mem_wmem_q;
  logic [XLEN-1:0] mem_sd_q;
  logic [RN_W-1:0] mem_rn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wreg_q  <= 1'b0;
      mem_m2reg_q <= 1'b0;
      mem_wmem_q  <= 1'b0;
      mem_alu_q   <= '0;
      mem_sd_q    <= '0;
      mem_rn_q    <= '0;
    end else begin
      mem_wreg_q  <= ex_ctrl_q.wreg;
      mem_m2reg_q <= ex_ctrl_q.m2reg;
      mem_wmem_q  <= ex_ctrl_q.wmem;
      mem_alu_q   <= ex_alu_y;
      mem_sd_q    <= ex_b_q;
      mem_rn_q    <= ex_rn_q;
    end
  end

  // memory
  logic               dm_we;
  logic [DMEM_AW-1:0] dm_waddr;
  logic [XLEN-1:0]    dm_wdata;

  assign dm_we    = dmem_ld_en_i | mem_wmem_q;
  assign dm_waddr = dmem_ld_en_i ? dmem_ld_addr_i : mem_alu_q[DMEM_AW+1:2];
  assign dm_wdata = dmem_ld_en_i ? dmem_ld_data_i : mem_sd_q;

  p5_ram #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (mem_alu_q[DMEM_AW+1:2]),
    .rdata (mem_rdata)
  );

  // memory / write-back register, with the data select folded in
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en_q   <= 1'b0;
      wb_rn_q   <= '0;
      wb_data_q <= '0;
    end else begin
      wb_en_q   <= mem_wreg_q;
      wb_rn_q   <= mem_rn_q;
      wb_data_q <= mem_m2reg_q ? mem_rdata : mem_alu_q;
    end
  end

  assign pc_o        = pc_q;
  assign dec_rs_o    = d_rs;
  assign dec_rt_o    = d_rt;
  assign ex_rn_o     = ex_rn_q;
  assign ex_wreg_o   = ex_ctrl_q.wreg;
  assign ex_m2reg_o  = ex_ctrl_q.m2reg;
  assign mem_rn_o    = mem_rn_q;
  assign mem_wreg_o  = mem_wreg_q;
  assign mem_m2reg_o = mem_m2reg_q;
  assign wb_en_o     = wb_en_q;
  assign wb_rn_o     = wb_rn_q;
  assign wb_data_o   = wb_data_q;

endmodule

// File: rtl/pipe5_chk.sv
module pipe5_chk #(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            stall_i,
  input logic [XLEN-1:0] pc_o,
  input logic [RW-1:0]   dec_rs_o,
  input logic [RW-1:0]   ex_rn_o,
  input logic            ex_wreg_o,
  input logic [RW-1:0]   mem_rn_o,
  input logic            mem_wreg_o,
  input logic            wb_en_o,
  input logic            st_we
);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && !wb_en_o && !ex_wreg_o && !mem_wreg_o));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !stall_i |=> pc_o == $past(pc_o) + XLEN'(4));

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> ($stable(pc_o) && $stable(dec_rs_o) && !ex_wreg_o));

  // R7
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    st_we |-> !mem_wreg_o);

  // R8
  wb_follow_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wreg_o |=> wb_en_o);

  // R8
  wb_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_wreg_o |=> !wb_en_o);

  // R13
  rn_flow_chk: assert property (@(posedge clk) disable iff (rst)
    ex_wreg_o |=> (mem_wreg_o && mem_rn_o == $past(ex_rn_o)));

endmodule

bind pipe5_core pipe5_chk #(.XLEN(XLEN), .RW(pipe5_pkg::RN_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .stall_i    (stall_i),
  .pc_o       (pc_o),
  .dec_rs_o   (dec_rs_o),
  .ex_rn_o    (ex_rn_o),
  .ex_wreg_o  (ex_wreg_o),
  .mem_rn_o   (mem_rn_o),
  .mem_wreg_o (mem_wreg_o),
  .wb_en_o    (wb_en_o),
  .st_we      (mem_wmem_q)
);

// File: tb/test_pipe5_core.sv
`timescale 1ns/1ps
module test_pipe5_core;

  localparam int IAW = 6;
  localparam int DAW = 6;
  localparam int NPROG = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall_i = 1'b0;
  logic [1:0]  fwd_a_i = 2'b00, fwd_b_i = 2'b00;
  logic        imem_ld_en_i = 1'b0;
  logic [IAW-1:0] imem_ld_addr_i = '0;
  logic [31:0] imem_ld_data_i = '0;
  logic        dmem_ld_en_i = 1'b0;
  logic [DAW-1:0] dmem_ld_addr_i = '0;
  logic [31:0] dmem_ld_data_i = '0;
  logic [31:0] pc_o, wb_data_o;
  logic [4:0]  dec_rs_o, dec_rt_o, ex_rn_o, mem_rn_o, wb_rn_o;
  logic        ex_wreg_o, ex_m2reg_o, mem_wreg_o, mem_m2reg_o, wb_en_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pipe5_core #(.XLEN(32), .IMEM_AW(IAW), .DMEM_AW(DAW)) i_pipe5_core (
    .clk(clk), .rst(rst), .stall_i(stall_i), .fwd_a_i(fwd_a_i), .fwd_b_i(fwd_b_i),
    .imem_ld_en_i(imem_ld_en_i), .imem_ld_addr_i(imem_ld_addr_i),
    .imem_ld_data_i(imem_ld_data_i), .dmem_ld_en_i(dmem_ld_en_i),
    .dmem_ld_addr_i(dmem_ld_addr_i), .dmem_ld_data_i(dmem_ld_data_i),
    .pc_o(pc_o), .dec_rs_o(dec_rs_o), .dec_rt_o(dec_rt_o), .ex_rn_o(ex_rn_o),
    .ex_wreg_o(ex_wreg_o), .ex_m2reg_o(ex_m2reg_o), .mem_rn_o(mem_rn_o),
    .mem_wreg_o(mem_wreg_o), .mem_m2reg_o(mem_m2reg_o), .wb_en_o(wb_en_o),
    .wb_rn_o(wb_rn_o), .wb_data_o(wb_data_o)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  typedef struct packed {
    logic [31:0] ir;
    logic [1:0]  fa;
    logic [1:0]  fb;
    logic        en;
    logic [4:0]  rn;
    logic [31:0] d;
  } vec_t;

  // data memory preload: word0 = 100, word1 = 7
  localparam vec_t VEC [NPROG] = '{
    '{enc_i(6'h23, 5'd0, 5'd1, 16'd0),  2'd0, 2'd0, 1'b1, 5'd1,  32'd100},  // R6 load dest = rt
    '{enc_i(6'h23, 5'd0, 5'd2, 16'd4),  2'd0, 2'd0, 1'b1, 5'd2,  32'd7},
    '{32'h0000_0000,                    2'd0, 2'd0, 1'b0, 5'd0,  32'd0},    // R3 no-op word
    '{enc_r(5'd1, 5'd2, 5'd3, 6'h20),   2'd0, 2'd3, 1'b1, 5'd3,  32'd107},  // R9 + R11 load data
    '{enc_r(5'd3, 5'd1, 5'd4, 6'h22),   2'd1, 2'd0, 1'b1, 5'd4,  32'd7},    // R11 exe
    '{enc_r(5'd4, 5'd3, 5'd5, 6'h24),   2'd1, 2'd2, 1'b1, 5'd5,  32'd3},    // R11 mem alu
    '{enc_r(5'd5, 5'd2, 5'd6, 6'h25),   2'd1, 2'd0, 1'b1, 5'd6,  32'd7},
    '{enc_i(6'h2B, 5'd0, 5'd3, 16'd8),  2'd0, 2'd0, 1'b0, 5'd0,  32'd0},    // R7 store r3 -> word2
    '{enc_i(6'h23, 5'd0, 5'd7, 16'd8),  2'd0, 2'd0, 1'b1, 5'd7,  32'd107},
    '{enc_r(5'd1, 5'd1, 5'd0, 6'h20),   2'd0, 2'd0, 1'b1, 5'd0,  32'd200},  // R10 write r0
    '{enc_r(5'd2, 5'd1, 5'd9, 6'h22),   2'd0, 2'd0, 1'b1, 5'd9,  32'hFFFF_FFA3}, // R4 wrap
    '{enc_i(6'h23, 5'd1, 5'd10, 16'hFFA4), 2'd0, 2'd0, 1'b1, 5'd10, 32'd107}, // R5 negative offset
    '{enc_r(5'd0, 5'd2, 5'd8, 6'h20),   2'd0, 2'd0, 1'b1, 5'd8,  32'd7}     // R10 r0 read as zero
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_imem(input int prog);
    for (int k = 0; k < (1 << IAW); k++) begin
      @(negedge clk);
      imem_ld_en_i   = 1'b1;
      imem_ld_addr_i = IAW'(k);
      if (prog == 0) imem_ld_data_i = (k < NPROG) ? VEC[k].ir : 32'h0;
      else begin
        case (k)
          0: imem_ld_data_i = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
          1: imem_ld_data_i = enc_r(5'd1, 5'd1, 5'd2, 6'h20);
          2: imem_ld_data_i = enc_r(5'd1, 5'd2, 5'd3, 6'h25);
          default: imem_ld_data_i = 32'h0;
        endcase
      end
    end
    @(negedge clk);
    imem_ld_en_i = 1'b0;
  endtask

  task automatic load_dmem();
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      dmem_ld_en_i   = 1'b1;
      dmem_ld_addr_i = DAW'(k);
      dmem_ld_data_i = (k == 0) ? 32'd100 : 32'd7;
    end
    @(negedge clk);
    dmem_ld_en_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    load_imem(0);
    load_dmem();
    @(negedge clk);
    // R1 reset state
    chk(pc_o == 32'd0, "R1 pc", pc_o, 32'd0);
    chk(!wb_en_o && !ex_wreg_o && !mem_wreg_o, "R1 flags",
        {29'd0, wb_en_o, ex_wreg_o, mem_wreg_o}, 32'd0);
    rst = 1'b0;

    // table walk: in cycle c decode holds c-1, write-back shows c-4
    for (int c = 1; c <= NPROG + 4; c++) begin
      @(posedge clk);
      @(negedge clk);
      chk(pc_o == 32'(4 * c), "R2 pc step", pc_o, 32'(4 * c));
      if (c >= 4 && c - 4 < NPROG) begin
        chk(wb_en_o == VEC[c-4].en, "R8 wb_en", {31'd0, wb_en_o}, {31'd0, VEC[c-4].en});
        if (VEC[c-4].en) begin
          chk(wb_rn_o == VEC[c-4].rn, "R6 wb_rn", {27'd0, wb_rn_o}, {27'd0, VEC[c-4].rn});
          chk(wb_data_o == VEC[c-4].d, "R8 wb_data", wb_data_o, VEC[c-4].d);
        end
      end
      if (c == 4) begin
        chk(dec_rs_o == 5'd1 && dec_rt_o == 5'd2, "R2 dec fields",
            {22'd0, dec_rs_o, dec_rt_o}, {22'd0, 5'd1, 5'd2});
        chk(mem_wreg_o && mem_m2reg_o && mem_rn_o == 5'd2 && !ex_wreg_o, "R13 stage info",
            {25'd0, mem_wreg_o, mem_m2reg_o, mem_rn_o}, {25'd0, 1'b1, 1'b1, 5'd2});
      end
      if (c == 9)
        chk(ex_m2reg_o == 1'b0 && ex_wreg_o == 1'b0, "R13 store in execute",
            {30'd0, ex_wreg_o, ex_m2reg_o}, 32'd0);
      if (c - 1 < NPROG) begin
        fwd_a_i = VEC[c-1].fa;
        fwd_b_i = VEC[c-1].fb;
      end else begin
        fwd_a_i = 2'b00;
        fwd_b_i = 2'b00;
      end
    end

    // directed: load-use stall then load-data forwarding
    rst = 1'b1;
    fwd_a_i = 2'b00;
    fwd_b_i = 2'b00;
    load_imem(1);
    @(negedge clk);
    chk(pc_o == 32'd0 && !wb_en_o, "R1 second reset", pc_o, 32'd0);
    rst = 1'b0;
    for (int c = 1; c <= 8; c++) begin
      @(posedge clk);
      @(negedge clk);
      stall_i = 1'b0;
      fwd_a_i = 2'b00;
      fwd_b_i = 2'b00;
      case (c)
        2: stall_i = 1'b1;
        3: begin
          chk(pc_o == 32'd8, "R12 pc held", pc_o, 32'd8);
          chk(dec_rs_o == 5'd1 && dec_rt_o == 5'd1, "R12 decode held",
              {22'd0, dec_rs_o, dec_rt_o}, {22'd0, 5'd1, 5'd1});
          chk(!ex_wreg_o, "R12 bubble", {31'd0, ex_wreg_o}, 32'd0);
          fwd_a_i = 2'b11;
          fwd_b_i = 2'b11;
        end
        4: begin
          chk(wb_en_o && wb_rn_o == 5'd1 && wb_data_o == 32'd100, "R8 load wb",
              wb_data_o, 32'd100);
          fwd_b_i = 2'b01;
        end
        5: chk(!wb_en_o, "R12 bubble reaches wb", {31'd0, wb_en_o}, 32'd0);
        6: chk(wb_en_o && wb_rn_o == 5'd2 && wb_data_o == 32'd200, "R11 load data fwd",
               wb_data_o, 32'd200);
        7: chk(wb_en_o && wb_rn_o == 5'd3 && wb_data_o == 32'd236, "R4 or result",
               wb_data_o, 32'd236);
        default: ;
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule